// File: doc/BRIEF.md
# Sequential Non-Restoring Integer Square Root

This unit takes an unsigned radicand and returns the floor of its square root together with a signed remainder. It settles one root bit per clock cycle, so a 32-bit radicand needs 16 iterations. It is meant to sit beside the bound computation of a lattice search controller. That controller pulses a start, waits for the done flag and reads both results.

The radicand is consumed two bits at a time, most significant pair first. At each step the running remainder is shifted left by two bits and the next pair is appended. The step then either subtracts `(root<<2)|1` or adds `(root<<2)|3`, and the sign of the old remainder decides which. The new root bit is the inverse of the sign of the new remainder. There is no restore step and no final fix-up. The root is always exact. The remainder is left raw and may be negative, and the caller corrects it if it needs the true value.

Top module: `sqrt_nr_top`

## Requirements
- R1: After reset, done_o is 0 and root_o and rem_o are 0.
- R2: A start_i sampled high while the unit is idle or done is accepted at that clock edge. done_o rises exactly ROOT_W edges later (16 for the default 32-bit radicand) and is low in between.
- R3: When done_o is high, root_o equals floor(sqrt(D)), where D is the radicand sampled at the accepting edge.
- R4: rem_o is a two's complement value REM_W = ROOT_W+2 bits wide. When done_o is high: if rem_o >= 0 then rem_o = D - root², otherwise rem_o + 2·root + 1 = D - root².
- R5: A start_i sampled high while a computation is in progress is ignored. The running computation keeps its radicand and its completion cycle.
- R6: Once done_o is high, done_o, root_o and rem_o hold their values until the next accepted start. done_o is low from the edge after that start.
- R7: radicand_i is sampled only at the accepting edge. Changes to it during a computation have no effect on the results.
- R8: With an 8-bit radicand of 140 the root is 11 and the remainder is 19.
- R9: During a computation, after k iterations root_o equals floor(sqrt(D >> 2·(ROOT_W−k))), that is, the root of the k leading radicand bit pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new computation (ignored while busy) |
| radicand_i | input | RAD_W (32) | Unsigned radicand, sampled when a start is accepted |
| done_o | output | 1 | Result valid, held until the next accepted start |
| root_o | output | ROOT_W (16) | Integer root (partial while computing) |
| rem_o | output | REM_W (18) | Uncorrected signed remainder |

## Verification
The assertions assume that start_i and radicand_i are free of X after reset. They also assume that the only event that clears done_o is a start accepted from the idle or done state. The bench drives every input on the falling edge, so each start is sampled as a clean single-cycle pulse. In the bench, the 8-bit configuration sweeps all 256 radicands and checks the partial root after every iteration. The 32-bit configuration covers the corner values 0, 1, perfect squares, their neighbours and all-ones, plus pseudo-random values. Some runs inject a second start and a changing radicand mid-computation to probe the rule that ignores starts while busy.

// File: rtl/sqrt_nr_pkg.sv
package sqrt_nr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/sqrt_nr_step.sv
module sqrt_nr_step #(
    parameter int ROOT_W = 16,
    parameter int REM_W  = ROOT_W + 2
) (
    input  logic [REM_W-1:0]  rem_i,
    input  logic [ROOT_W-1:0] root_i,
    input  logic [1:0]        pair_i,
    output logic [REM_W-1:0]  rem_o,
    output logic [ROOT_W-1:0] root_o
);

    logic [REM_W-1:0] shifted;
    logic [REM_W-1:0] sub_term;
    logic [REM_W-1:0] add_term;

    always_comb begin
        shifted  = {rem_i[REM_W-3:0], pair_i};
        sub_term = {root_i, 2'b01};
        add_term = {root_i, 2'b11};
        if (!rem_i[REM_W-1]) begin
            rem_o = shifted - sub_term;
        end else begin
            rem_o = shifted + add_term;
        end
        root_o = {root_i[ROOT_W-2:0], ~rem_o[REM_W-1]};
    end

endmodule

// File: rtl/sqrt_nr_ctrl.sv
module sqrt_nr_ctrl #(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    import sqrt_nr_pkg::*;

    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_s;

    ctrl_s ctrl_d;
    ctrl_s ctrl_q;
    logic  accept;

    always_comb begin
        ctrl_d = ctrl_q;
        accept = start_i && (ctrl_q.phase != PH_RUN);
        if (ctrl_q.phase == PH_RUN) begin
            if (ctrl_q.cnt == '0) begin
                ctrl_d.phase = PH_DONE;
            end else begin
                ctrl_d.cnt = ctrl_q.cnt - CNT_W'(1);
            end
        end
        if (accept) begin
            ctrl_d.phase = PH_RUN;
            ctrl_d.cnt   = CNT_W'(STEPS - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load_o = accept;
    assign step_o = (ctrl_q.phase == PH_RUN);
    assign busy_o = (ctrl_q.phase == PH_RUN);
    assign done_o = (ctrl_q.phase == PH_DONE);

    // R2: the iteration counter walks down by one on each busy cycle
    assert_count_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && ctrl_q.cnt != '0 |=> busy_o && ctrl_q.cnt == $past(ctrl_q.cnt) - CNT_W'(1));

    // R2: the last iteration leads straight to done
    assert_run_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && ctrl_q.cnt == '0 |=> done_o);

    // R5: a start seen while busy does not reload the counter
    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && ctrl_q.cnt != '0 |=> ctrl_q.cnt != CNT_W'(STEPS - 1));

endmodule

// File: rtl/sqrt_nr_top.sv
module sqrt_nr_top #(
    parameter int RAD_W  = 32,
    parameter int ROOT_W = RAD_W / 2,
    parameter int REM_W  = ROOT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RAD_W-1:0]  radicand_i,
    output logic              done_o,
    output logic [ROOT_W-1:0] root_o,
    output logic [REM_W-1:0]  rem_o
);

    typedef struct packed {
        logic [RAD_W-1:0]  rad;
        logic [REM_W-1:0]  rem;
        logic [ROOT_W-1:0] root;
    } dp_s;

    dp_s               dp_d;
    dp_s               dp_q;
    logic              load;
    logic              step;
    logic              busy;
    logic [REM_W-1:0]  rem_nx;
    logic [ROOT_W-1:0] root_nx;

    sqrt_nr_ctrl #(.STEPS(ROOT_W)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .load_o (load),
        .step_o (step),
        .busy_o (busy),
        .done_o (done_o)
    );

    sqrt_nr_step #(.ROOT_W(ROOT_W), .REM_W(REM_W)) step_i (
        .rem_i (dp_q.rem),
        .root_i(dp_q.root),
        .pair_i(dp_q.rad[RAD_W-1 -: 2]),
        .rem_o (rem_nx),
        .root_o(root_nx)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.rad  = radicand_i;
            dp_d.rem  = '0;
            dp_d.root = '0;
        end else if (step) begin
            dp_d.rad  = {dp_q.rad[RAD_W-3:0], 2'b00};
            dp_d.rem  = rem_nx;
            dp_d.root = root_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign root_o = dp_q.root;
    assign rem_o  = dp_q.rem;

    // wide views for the remainder bound check
    logic signed [REM_W:0] rem_wide;
    logic signed [REM_W:0] twice_root;
    always_comb begin
        rem_wide   = $signed({dp_q.rem[REM_W-1], dp_q.rem});
        twice_root = $signed({2'b00, dp_q.root, 1'b0});
    end

    // R9: each iteration shifts one new bit into the root
    assert_root_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> dp_q.root[ROOT_W-1:1] == $past(dp_q.root[ROOT_W-2:0]));

    // R4: final remainder lies in [-(2Q+1), 2Q]
    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_wide <= twice_root) && (rem_wide + twice_root + 1 >= 0));

    // R3: the last root bit agrees with the sign of the final remainder
    assert_last_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> dp_q.root[0] == ~dp_q.rem[REM_W-1]);

    // R6: results hold while done and no new start arrives
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(dp_q.root) && $stable(dp_q.rem));

endmodule

// File: tb/sqrt_nr_top_tb_top.sv
module sqrt_nr_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // 32-bit configuration
    logic        st32 = 1'b0;
    logic [31:0] rad32 = '0;
    logic        done32;
    logic [15:0] root32;
    logic [17:0] rem32;

    // 8-bit configuration
    logic       st8 = 1'b0;
    logic [7:0] rad8 = '0;
    logic       done8;
    logic [3:0] root8;
    logic [5:0] rem8;

    sqrt_nr_top #(.RAD_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(st32), .radicand_i(rad32),
        .done_o(done32), .root_o(root32), .rem_o(rem32)
    );

    sqrt_nr_top #(.RAD_W(8)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .start_i(st8), .radicand_i(rad8),
        .done_o(done8), .root_o(root8), .rem_o(rem8)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint isqrt(input longint x);
        longint r = 0;
        for (int b = 20; b >= 0; b--) begin
            longint c = r | (longint'(1) << b);
            if (c * c <= x) r = c;
        end
        return r;
    endfunction

    task automatic check_result(input string tag, input longint d, input longint q, input longint rs);
        longint fixed;
        chk(q == isqrt(d), {tag, " R3 root"}, q, isqrt(d));
        fixed = (rs < 0) ? rs + 2 * q + 1 : rs;
        chk(fixed == d - q * q, {tag, " R4 remainder"}, rs, d - q * q);
    endtask

    task automatic run_big(input logic [31:0] d, input bit poke);
        @(negedge clk);
        st32 = 1'b1;
        rad32 = d;
        @(negedge clk);
        st32 = 1'b0;
        rad32 = ~d;   // R7 disturbance while busy
        for (int i = 0; i < 15; i++) begin
            if (poke && i == 6) begin
                st32 = 1'b1;               // R5 start while busy
                rad32 = d ^ 32'h5A5A_0F0F;
            end else begin
                st32 = 1'b0;
            end
            @(negedge clk);
        end
        st32 = 1'b0;
        chk(done32 == 1'b0, "R2 done early", done32, 0);
        @(negedge clk);
        chk(done32 == 1'b1, poke ? "R5 done timing" : "R2 done timing", done32, 1);
        check_result(poke ? "R5/R7" : "R3/R4", longint'(d), longint'(root32),
                     longint'($signed(rem32)));
    endtask

    task automatic run_small(input int d);
        @(negedge clk);
        st8 = 1'b1;
        rad8 = 8'(d);
        @(negedge clk);
        st8 = 1'b0;
        rad8 = 8'(~d);
        chk(root8 == 4'd0, "R9 root cleared", root8, 0);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk(longint'(root8) == isqrt(longint'(d >> (2 * (4 - k)))), "R9 partial root",
                root8, isqrt(longint'(d >> (2 * (4 - k)))));
            if (k < 4) chk(done8 == 1'b0, "R2 small done early", done8, 0);
        end
        chk(done8 == 1'b1, "R2 small done", done8, 1);
        check_result("small", longint'(d), longint'(root8), longint'($signed(rem8)));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] lfsr = 32'hACE1_2468;
        logic [15:0] held_root;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done32 == 1'b0, "R1 done", done32, 0);
        chk(root32 == '0, "R1 root", root32, 0);
        chk(rem32 == '0, "R1 rem", rem32, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 worked example
        run_small(140);
        chk(root8 == 4'd11, "R8 root", root8, 11);
        chk($signed(rem8) == 6'sd19, "R8 rem", $signed(rem8), 19);

        // exhaustive small sweep (R3, R4, R9)
        for (int d = 0; d < 256; d++) run_small(d);

        // 32-bit corners
        run_big(32'd0, 1'b0);
        run_big(32'd1, 1'b0);
        run_big(32'd2, 1'b0);
        run_big(32'hFFFF_FFFF, 1'b0);
        run_big(32'hFFFE_0001, 1'b0);
        run_big(32'hFFFE_0000, 1'b0);
        run_big(32'h4000_0000, 1'b0);
        run_big(32'h3FFF_FFFF, 1'b0);

        // R6: hold after done, then clear on next start
        held_root = root32;
        repeat (5) @(negedge clk);
        chk(done32 == 1'b1, "R6 done held", done32, 1);
        chk(root32 == held_root, "R6 root held", root32, held_root);
        st32 = 1'b1;
        rad32 = 32'd81;
        @(negedge clk);
        st32 = 1'b0;
        chk(done32 == 1'b0, "R6 done cleared", done32, 0);
        repeat (16) @(negedge clk);
        chk(root32 == 16'd9, "R6 restart root", root32, 9);

        // random radicands, some with an injected start while busy
        for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run_big(lfsr, (n % 4) == 1);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule